// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block produces the control strobes for a single access on a multiplexed external peripheral bus. Such a bus typically serves a boot ROM and other simple devices. A requester presents a region number and a beat count. The block takes that region's timing from one of eight parallel configuration sets and latches it for the whole access. It then drives an address-latch strobe, an active-low chip select and a one-cycle data sample strobe. A region can run in one of two modes. In fixed-cycle mode, every beat takes a set number of cycles. In acknowledge mode, the sequencer waits for the device's ready input. A watchdog in acknowledge mode ends the access if ready never arrives.

A region whose programmed flag is clear uses built-in defaults. Region 0 defaults to slow boot timing, and every other region defaults to the fastest timing. The chip-select width field means different things in the two modes. In fixed-cycle mode it is the strobe length. In acknowledge mode it is the delay before ready is first examined. An early-select option pulls the external chip select low during the address phases and leaves the cycle timing alone.

Top module: `ebs_strobe_seq`

## Requirements
- R1: While the synchronous reset `rst` is high and in the cycle after it, `busy`, `ale`, `smp`, `done` and `err` are 0 and `cs_n` is 1.
- R2: A request selects region `req_region`. When `cfg_prog[r]` is 0, region r uses defaults: region 0 uses latch 4, gap 2, select 24, sample delay 1, beat gap 1, fixed-cycle mode and no early select; every other region uses 1 for all counts and fixed-cycle mode.
- R3: After a request is accepted in an idle cycle, `ale` is high for exactly the latch-width count of cycles, starting with the cycle after acceptance.
- R4: `cs_n` goes low exactly gap-count cycles after `ale` falls. Between those two points the bus is in the gap phase.
- R5: In fixed-cycle mode (`cfg_ack[r]`=0), each beat holds `cs_n` low for the select-width count of cycles, and `smp` pulses in the last of those cycles.
- R6: In acknowledge mode (`cfg_ack[r]`=1), `rdy` is ignored during the first select-width cycles of each beat. From then on it is checked every cycle, and `smp` pulses sample-delay cycles after the cycle in which `rdy` was seen high.
- R7: With `cfg_early[r]`=1, `cs_n` is also low during the latch and gap phases, and every strobe keeps the same cycle position.
- R8: An access has `req_beats`+1 beats. Between consecutive beats, `cs_n` stays low for beat-gap-count idle cycles, and each beat restarts its select-width phase.
- R9: A value of 0 in any count field (latch, gap, select, sample delay, beat gap) behaves as 1.
- R10: `busy` is high from the cycle after acceptance through the cycle of the final `smp`. `done` pulses for one cycle together with the final `smp`.
- R11: If `rdy` stays low for 256 checked cycles, the access ends in the 256th cycle with `done` and no `smp`. After that, `err` is high until the next request is accepted. Ready seen in the 256th checked cycle is a normal completion.
- R12: `req_valid` has no effect while `busy` is high.
- R13: Raising `rst` in the middle of an access returns the block to idle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_region | input | 3 | Region number of the request |
| req_beats | input | 3 | Beat count minus one |
| cfg_prog | input | 8 | Per-region flag: use the programmed fields instead of the defaults |
| cfg_latch_w | input | 24 | Latch-strobe width, 3 bits per region (region r at bits 3r+2:3r) |
| cfg_gap | input | 16 | Latch-to-select gap, 2 bits per region |
| cfg_sel_w | input | 40 | Select width or ready delay, 5 bits per region |
| cfg_smp_dly | input | 24 | Ready-to-sample delay, 3 bits per region |
| cfg_beat_gap | input | 16 | Gap between beats, 2 bits per region |
| cfg_early | input | 8 | Per-region early chip-select enable |
| cfg_ack | input | 8 | Per-region acknowledge mode |
| rdy | input | 1 | Device ready |
| ale | output | 1 | Address-latch strobe, active high |
| cs_n | output | 1 | Chip select, active low |
| smp | output | 1 | Data sample strobe |
| done | output | 1 | Access-end pulse |
| busy | output | 1 | Access in progress |
| err | output | 1 | Last acknowledge access timed out |

## Verification
Two functions can land in the same cycle: the ready check and the end of the watchdog window. The bench provokes this by raising `rdy` in exactly the 256th checked cycle. It expects a normal sample after the sample delay, with `err` staying low. A separate access withholds ready so that the timeout fires and raises `err`. The next accepted request must clear `err` again.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   localparam int LAT_W = 3;
   localparam int GAP_W = 2;
   localparam int SEL_W = 5;
   localparam int SMP_W = 3;
   localparam int BG_W  = 2;
   localparam int CNT_W = 5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ALE, ST_GAP, ST_STRB, ST_CHK, ST_SMPD, ST_BGAP
   } ebs_state_e;

   typedef struct packed {
      logic [LAT_W-1:0] latch;
      logic [GAP_W-1:0] gap;
      logic [SEL_W-1:0] sel;
      logic [SMP_W-1:0] smp;
      logic [BG_W-1:0]  bgap;
      logic             early;
      logic             ack;
   } ebs_cfg_t;

   function automatic ebs_cfg_t ebs_clamp(input ebs_cfg_t c);
      ebs_cfg_t o;
      o = c;
      if (c.latch == '0) o.latch = LAT_W'(1);
      if (c.gap   == '0) o.gap   = GAP_W'(1);
      if (c.sel   == '0) o.sel   = SEL_W'(1);
      if (c.smp   == '0) o.smp   = SMP_W'(1);
      if (c.bgap  == '0) o.bgap  = BG_W'(1);
      return o;
   endfunction
endpackage

// File: rtl/ebs_cfg_mux.sv
module ebs_cfg_mux
   import ebs_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int IDX_W = 3,
   parameter logic [LAT_W-1:0] BOOT_LATCH = 3'd4,
   parameter logic [GAP_W-1:0] BOOT_GAP   = 2'd2,
   parameter logic [SEL_W-1:0] BOOT_SEL   = 5'd24
) (
   input  logic [IDX_W-1:0]             idx,
   input  logic [NUM_REGIONS-1:0]       cfg_prog,
   input  logic [NUM_REGIONS*LAT_W-1:0] cfg_latch_w,
   input  logic [NUM_REGIONS*GAP_W-1:0] cfg_gap,
   input  logic [NUM_REGIONS*SEL_W-1:0] cfg_sel_w,
   input  logic [NUM_REGIONS*SMP_W-1:0] cfg_smp_dly,
   input  logic [NUM_REGIONS*BG_W-1:0]  cfg_beat_gap,
   input  logic [NUM_REGIONS-1:0]       cfg_early,
   input  logic [NUM_REGIONS-1:0]       cfg_ack,
   output ebs_cfg_t                     sel_cfg
);
   ebs_cfg_t eff [NUM_REGIONS];

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      ebs_cfg_t dflt;
      ebs_cfg_t prog;
      if (g == 0) begin : g_boot
         assign dflt = '{latch: BOOT_LATCH, gap: BOOT_GAP, sel: BOOT_SEL,
                         smp: SMP_W'(1), bgap: BG_W'(1), early: 1'b0, ack: 1'b0};
      end else begin : g_plain
         assign dflt = '{latch: LAT_W'(1), gap: GAP_W'(1), sel: SEL_W'(1),
                         smp: SMP_W'(1), bgap: BG_W'(1), early: 1'b0, ack: 1'b0};
      end
      assign prog = '{latch: cfg_latch_w[g*LAT_W +: LAT_W],
                      gap:   cfg_gap[g*GAP_W +: GAP_W],
                      sel:   cfg_sel_w[g*SEL_W +: SEL_W],
                      smp:   cfg_smp_dly[g*SMP_W +: SMP_W],
                      bgap:  cfg_beat_gap[g*BG_W +: BG_W],
                      early: cfg_early[g],
                      ack:   cfg_ack[g]};
      assign eff[g] = ebs_clamp(cfg_prog[g] ? prog : dflt);
   end

   assign sel_cfg = eff[idx];
endmodule

// File: rtl/ebs_tmo.sv
module ebs_tmo #(
   parameter int LIMIT = 256,
   localparam int TW = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output logic last
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt_q <= '0;
      else if (inc)    cnt_q <= cnt_q + TW'(1);
   end

   assign last = (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/ebs_fsm.sv
module ebs_fsm
   import ebs_pkg::*;
#(
   parameter int BEAT_W = 3,
   parameter int TMO_CYCLES = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [BEAT_W-1:0] req_beats,
   input  ebs_cfg_t          cfg_in,
   input  logic              rdy,
   output logic              ale,
   output logic              cs_n,
   output logic              smp,
   output logic              done,
   output logic              busy,
   output logic              err
);
   ebs_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] left_q;
   ebs_cfg_t          cfg_q;
   logic              err_q;
   logic              cnt_one;
   logic              tmo_last;
   logic              last_beat;

   ebs_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
      .clk  (clk),
      .rst  (rst),
      .clr  (st_q != ST_CHK),
      .inc  (st_q == ST_CHK && !rdy),
      .last (tmo_last)
   );

   assign cnt_one   = (cnt_q == CNT_W'(1));
   assign last_beat = (left_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         left_q <= '0;
         cfg_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               cfg_q  <= cfg_in;
               left_q <= req_beats;
               err_q  <= 1'b0;
               cnt_q  <= CNT_W'(cfg_in.latch);
               st_q   <= ST_ALE;
            end
            ST_ALE: if (cnt_one) begin
               cnt_q <= CNT_W'(cfg_q.gap);
               st_q  <= ST_GAP;
            end else cnt_q <= cnt_q - CNT_W'(1);
            ST_GAP: if (cnt_one) begin
               cnt_q <= CNT_W'(cfg_q.sel);
               st_q  <= ST_STRB;
            end else cnt_q <= cnt_q - CNT_W'(1);
            ST_STRB: if (cnt_one) begin
               if (cfg_q.ack) st_q <= ST_CHK;
               else if (last_beat) st_q <= ST_IDLE;
               else begin
                  left_q <= left_q - BEAT_W'(1);
                  cnt_q  <= CNT_W'(cfg_q.bgap);
                  st_q   <= ST_BGAP;
               end
            end else cnt_q <= cnt_q - CNT_W'(1);
            ST_CHK: if (rdy) begin
               cnt_q <= CNT_W'(cfg_q.smp);
               st_q  <= ST_SMPD;
            end else if (tmo_last) begin
               err_q <= 1'b1;
               st_q  <= ST_IDLE;
            end
            ST_SMPD: if (cnt_one) begin
               if (last_beat) st_q <= ST_IDLE;
               else begin
                  left_q <= left_q - BEAT_W'(1);
                  cnt_q  <= CNT_W'(cfg_q.bgap);
                  st_q   <= ST_BGAP;
               end
            end else cnt_q <= cnt_q - CNT_W'(1);
            ST_BGAP: if (cnt_one) begin
               cnt_q <= CNT_W'(cfg_q.sel);
               st_q  <= ST_STRB;
            end else cnt_q <= cnt_q - CNT_W'(1);
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ale  = (st_q == ST_ALE);
      busy = (st_q != ST_IDLE);
      cs_n = !((st_q == ST_STRB) || (st_q == ST_CHK) || (st_q == ST_SMPD) ||
               (st_q == ST_BGAP) ||
               (cfg_q.early && ((st_q == ST_ALE) || (st_q == ST_GAP))));
      smp  = ((st_q == ST_STRB) && cnt_one && !cfg_q.ack) ||
             ((st_q == ST_SMPD) && cnt_one);
      done = (smp && last_beat) || ((st_q == ST_CHK) && !rdy && tmo_last);
      err  = err_q;
   end
endmodule

// File: rtl/ebs_strobe_seq.sv
module ebs_strobe_seq
   import ebs_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int BEAT_W = 3,
   parameter int TMO_CYCLES = 256,
   parameter logic [LAT_W-1:0] BOOT_LATCH = 3'd4,
   parameter logic [GAP_W-1:0] BOOT_GAP   = 2'd2,
   parameter logic [SEL_W-1:0] BOOT_SEL   = 5'd24,
   localparam int IDX_W = $clog2(NUM_REGIONS)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         req_valid,
   input  logic [IDX_W-1:0]             req_region,
   input  logic [BEAT_W-1:0]            req_beats,
   input  logic [NUM_REGIONS-1:0]       cfg_prog,
   input  logic [NUM_REGIONS*LAT_W-1:0] cfg_latch_w,
   input  logic [NUM_REGIONS*GAP_W-1:0] cfg_gap,
   input  logic [NUM_REGIONS*SEL_W-1:0] cfg_sel_w,
   input  logic [NUM_REGIONS*SMP_W-1:0] cfg_smp_dly,
   input  logic [NUM_REGIONS*BG_W-1:0]  cfg_beat_gap,
   input  logic [NUM_REGIONS-1:0]       cfg_early,
   input  logic [NUM_REGIONS-1:0]       cfg_ack,
   input  logic                         rdy,
   output logic                         ale,
   output logic                         cs_n,
   output logic                         smp,
   output logic                         done,
   output logic                         busy,
   output logic                         err
);
   if (NUM_REGIONS < 2 || (1 << IDX_W) != NUM_REGIONS) begin : g_bad_regions
      $error("NUM_REGIONS must be a power of two of at least 2");
   end
   if (BEAT_W < 1) begin : g_bad_beats
      $error("BEAT_W must be at least 1");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("TMO_CYCLES must be at least 2");
   end

   ebs_cfg_t sel_cfg;

   ebs_cfg_mux #(
      .NUM_REGIONS (NUM_REGIONS),
      .IDX_W       (IDX_W),
      .BOOT_LATCH  (BOOT_LATCH),
      .BOOT_GAP    (BOOT_GAP),
      .BOOT_SEL    (BOOT_SEL)
   ) u_mux (
      .idx          (req_region),
      .cfg_prog     (cfg_prog),
      .cfg_latch_w  (cfg_latch_w),
      .cfg_gap      (cfg_gap),
      .cfg_sel_w    (cfg_sel_w),
      .cfg_smp_dly  (cfg_smp_dly),
      .cfg_beat_gap (cfg_beat_gap),
      .cfg_early    (cfg_early),
      .cfg_ack      (cfg_ack),
      .sel_cfg      (sel_cfg)
   );

   ebs_fsm #(.BEAT_W(BEAT_W), .TMO_CYCLES(TMO_CYCLES)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_beats (req_beats),
      .cfg_in    (sel_cfg),
      .rdy       (rdy),
      .ale       (ale),
      .cs_n      (cs_n),
      .smp       (smp),
      .done      (done),
      .busy      (busy),
      .err       (err)
   );
endmodule

// File: rtl/ebs_strobe_seq_chk.sv
module ebs_strobe_seq_chk (
   input logic clk,
   input logic rst,
   input logic req_valid,
   input logic ale,
   input logic cs_n,
   input logic smp,
   input logic done,
   input logic busy,
   input logic err
);
   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && cs_n && !ale && !err)); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (cs_n && !ale && !smp && !done)); // R10
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R10
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R10
   AST_SMP_UNDER_CS: assert property (@(posedge clk) disable iff (rst) smp |-> !cs_n); // R5
   AST_ALE_NO_SMP: assert property (@(posedge clk) disable iff (rst) ale |-> !smp); // R3
   AST_START_REQ: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(req_valid)); // R12
   AST_START_ALE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> ale); // R3
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !err); // R11
   AST_ERR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> $past(done)); // R11
endmodule

bind ebs_strobe_seq ebs_strobe_seq_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .ale       (ale),
   .cs_n      (cs_n),
   .smp       (smp),
   .done      (done),
   .busy      (busy),
   .err       (err)
);

// File: tb/ebs_strobe_seq_tb_top.sv
module ebs_strobe_seq_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0;
   logic [2:0] req_region = '0;
   logic [2:0] req_beats = '0;
   logic rdy = 1'b0;
   logic [7:0]  cfg_prog = '0, cfg_early = '0, cfg_ack = '0;
   logic [23:0] cfg_latch_w, cfg_smp_dly;
   logic [15:0] cfg_gap, cfg_beat_gap;
   logic [39:0] cfg_sel_w;
   logic ale, cs_n, smp, done, busy, err;

   logic [2:0] r_lat [8];
   logic [1:0] r_gap [8];
   logic [4:0] r_sel [8];
   logic [2:0] r_smp [8];
   logic [1:0] r_bg  [8];

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   typedef struct { bit ale; bit csn; bit smp; bit done; bit rdy; } ent_t;
   ent_t q[$];
   bit exp_to;

   always #10 clk = ~clk;

   always_comb begin
      for (int r = 0; r < 8; r++) begin
         cfg_latch_w[r*3 +: 3] = r_lat[r];
         cfg_gap[r*2 +: 2]     = r_gap[r];
         cfg_sel_w[r*5 +: 5]   = r_sel[r];
         cfg_smp_dly[r*3 +: 3] = r_smp[r];
         cfg_beat_gap[r*2 +: 2] = r_bg[r];
      end
   end

   ebs_strobe_seq dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_region(req_region),
      .req_beats(req_beats), .cfg_prog(cfg_prog), .cfg_latch_w(cfg_latch_w),
      .cfg_gap(cfg_gap), .cfg_sel_w(cfg_sel_w), .cfg_smp_dly(cfg_smp_dly),
      .cfg_beat_gap(cfg_beat_gap), .cfg_early(cfg_early), .cfg_ack(cfg_ack),
      .rdy(rdy), .ale(ale), .cs_n(cs_n), .smp(smp), .done(done), .busy(busy), .err(err)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int one(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic push(bit a, bit c, bit s, bit d, bit y);
      ent_t e;
      e.ale = a; e.csn = c; e.smp = s; e.done = d; e.rdy = y;
      q.push_back(e);
   endtask

   // Reference: build the expected per-cycle trace of one access.
   task automatic build(int r, int nb, bit rdy_early, int k0, int k1);
      int lw, gw, sw, dw, bw;
      bit ea, ak;
      q.delete();
      exp_to = 0;
      if (cfg_prog[r]) begin
         lw = one(r_lat[r]); gw = one(r_gap[r]); sw = one(r_sel[r]);
         dw = one(r_smp[r]); bw = one(r_bg[r]); ea = cfg_early[r]; ak = cfg_ack[r];
      end else begin
         lw = (r == 0) ? 4 : 1; gw = (r == 0) ? 2 : 1; sw = (r == 0) ? 24 : 1;
         dw = 1; bw = 1; ea = 0; ak = 0;
      end
      for (int i = 0; i < lw; i++) push(1, !ea, 0, 0, 0);
      for (int i = 0; i < gw; i++) push(0, !ea, 0, 0, 0);
      for (int b = 0; b < nb; b++) begin
         bit last;
         int k;
         last = (b == nb - 1);
         if (!ak) begin
            for (int i = 0; i < sw; i++) push(0, 0, i == sw-1, last && i == sw-1, 0);
         end else begin
            for (int i = 0; i < sw; i++) push(0, 0, 0, 0, rdy_early);
            k = (b == 0) ? k0 : k1;
            if (k == 0) begin
               for (int i = 0; i < 256; i++) push(0, 0, 0, i == 255, 0);
               exp_to = 1;
               break;
            end
            for (int i = 0; i < k - 1; i++) push(0, 0, 0, 0, 0);
            push(0, 0, 0, 0, 1);
            for (int i = 0; i < dw; i++) push(0, 0, i == dw-1, last && i == dw-1, 0);
         end
         if (!last) for (int i = 0; i < bw; i++) push(0, 0, 0, 0, 0);
      end
   endtask

   task automatic run(string tag, int r, int beats_m1, bit rdy_early, int k0, int k1, bit hold);
      build(r, beats_m1 + 1, rdy_early, k0, k1);
      @(negedge clk);
      req_valid = 1; req_region = 3'(r); req_beats = 3'(beats_m1);
      @(negedge clk);
      if (hold) begin
         req_region = 3'((r + 1) % 8); req_beats = 3'd7;
      end else req_valid = 0;
      for (int i = 0; i < q.size(); i++) begin
         rdy = q[i].rdy;
         if (hold && i == 3) req_valid = 0;
         #1;
         chk(tag, "ale", ale, q[i].ale);
         chk(tag, "cs_n", cs_n, q[i].csn);
         chk(tag, "smp", smp, q[i].smp);
         chk(tag, "done", done, q[i].done);
         chk(tag, "busy", busy, 1);
         chk(tag, "err", err, 0);
         @(negedge clk);
      end
      rdy = 0;
      #1;
      chk(tag, "idle busy", busy, 0);
      chk(tag, "idle cs_n", cs_n, 1);
      chk(tag, "idle ale", ale, 0);
      chk(tag, "idle err (R11)", err, exp_to);
   endtask

   initial begin
      for (int r = 0; r < 8; r++) begin
         r_lat[r] = '0; r_gap[r] = '0; r_sel[r] = '0; r_smp[r] = '0; r_bg[r] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "busy", busy, 0); chk("R1", "cs_n", cs_n, 1); chk("R1", "ale", ale, 0);
      chk("R1", "smp", smp, 0); chk("R1", "done", done, 0); chk("R1", "err", err, 0);
      @(negedge clk); rst = 0;

      run("R2 boot defaults R10", 0, 0, 0, 0, 0, 0);
      run("R2 plain defaults", 3, 0, 0, 0, 0, 0);

      cfg_prog[1] = 1; r_lat[1] = 5; r_gap[1] = 3; r_sel[1] = 6;
      run("R3 R4 R5 fixed", 1, 0, 0, 0, 0, 0);

      cfg_prog[2] = 1; cfg_early[2] = 1; r_lat[2] = 2; r_gap[2] = 1; r_sel[2] = 3;
      run("R7 early select", 2, 0, 0, 0, 0, 0);

      cfg_prog[4] = 1; r_lat[4] = 1; r_gap[4] = 2; r_sel[4] = 2; r_bg[4] = 3;
      run("R8 fixed burst", 4, 2, 0, 0, 0, 0);

      cfg_prog[5] = 1;
      run("R9 zero fields", 5, 1, 0, 0, 0, 0);

      cfg_prog[6] = 1; cfg_ack[6] = 1; r_lat[6] = 1; r_gap[6] = 1; r_sel[6] = 4; r_smp[6] = 3; r_bg[6] = 2;
      run("R6 ack ready ignored early", 6, 0, 1, 5, 0, 0);
      run("R6 R8 ack burst", 6, 1, 0, 1, 3, 0);

      cfg_prog[7] = 1; cfg_ack[7] = 1; r_lat[7] = 2; r_gap[7] = 1; r_sel[7] = 2; r_smp[7] = 2;
      run("R11 timeout", 7, 0, 0, 0, 0, 0);
      run("R11 ready at last check", 7, 0, 0, 256, 0, 0);

      run("R12 request while busy", 1, 1, 0, 0, 0, 1);
      @(negedge clk); #1;
      chk("R12", "no extra access busy", busy, 0);

      @(negedge clk);
      req_valid = 1; req_region = 0; req_beats = 0;
      @(negedge clk); req_valid = 0;
      repeat (4) @(negedge clk);
      rst = 1;
      @(negedge clk); #1;
      chk("R13", "busy", busy, 0); chk("R13", "cs_n", cs_n, 1); chk("R13", "ale", ale, 0);
      rst = 0;
      @(negedge clk); #1;
      chk("R13", "stays idle", busy, 0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule